// File: doc/BRIEF.md
# Trap Entry and Handler Vector Unit

This block manages trap entry for a 32-bit processor pipeline with a coprocessor-style control register set. When a one-cycle exception request arrives, it saves the return address, notes whether the faulting instruction was in a branch delay slot, records the exception code, and raises the exception-level flag. It then works out the handler address from a base and an offset and passes it to instruction fetch.

The base depends on the boot-vector flag. The offset depends on four things: whether the unit was already at exception level, the class of the exception, the TLB no-match qualifier, and the interrupt-vector bit. If the unit was already at exception level, the saved return address and the delay-slot bit stay as they are, so a nested fault cannot overwrite them. A return request clears the exception-level flag and redirects fetch to the saved address. A simple software write port updates the return address and the control bits. Exception requests take priority over return requests, and return requests take priority over writes.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, exl_o, bev_o, iv_o and bd_o are 0, epc_o and cause_code_o are 0, and redirect_o is 0.
- R2: An exception taken while exl_o is 0 and exc_in_dslot is 0 loads epc_o with exc_pc and clears bd_o.
- R3: An exception taken while exl_o is 0 and exc_in_dslot is 1 loads epc_o with exc_pc minus 4 and sets bd_o.
- R4: An exception taken while exl_o is 1 leaves epc_o and bd_o unchanged and uses offset 0x180.
- R5: Exception codes 2 and 3 (TLB load and TLB store), taken while exl_o is 0, use offset 0x000 when exc_tlb_nomatch is 1 and offset 0x180 when it is 0.
- R6: Exception code 0 (interrupt), taken while exl_o is 0, uses offset 0x200 when iv_o is 1 and offset 0x180 when iv_o is 0.
- R7: Every other exception code uses offset 0x180.
- R8: Every exception sets exl_o to 1 and writes exc_code into cause_code_o, whatever the earlier value of exl_o.
- R9: redirect_pc_o for an exception is the base plus the offset. The base is 0x80000000 when bev_o is 0 and 0xBFC00200 when bev_o is 1.
- R10: redirect_o is high in exactly the cycle after each exception or return request, and redirect_pc_o is valid in that cycle. When no request was made in the previous cycle, redirect_o is 0.
- R11: A return request without an exception request clears exl_o and redirects to the value epc_o held when the request was made.
- R12: When an exception request and a return request arrive together, only the exception takes effect.
- R13: A software write with sw_wr_sel 0 loads epc_o from sw_wr_data. With sw_wr_sel 1, it loads exl_o from bit 1 and bev_o from bit 22. With sw_wr_sel 2, it loads iv_o from bit 23. With sw_wr_sel 3, it changes nothing. A write made in the same cycle as an exception or return request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_code | input | 5 | Exception code of the request |
| exc_tlb_nomatch | input | 1 | TLB lookup found no matching entry |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_dslot | input | 1 | Faulting instruction is in a branch delay slot |
| eret_req | input | 1 | One-cycle return-from-exception request |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_sel | input | 2 | Write target: 0 return address, 1 status, 2 cause, 3 none |
| sw_wr_data | input | 32 | Write data |
| epc_o | output | 32 | Saved return address |
| exl_o | output | 1 | Exception-level flag |
| bev_o | output | 1 | Boot-vector flag |
| iv_o | output | 1 | Interrupt-vector select bit |
| bd_o | output | 1 | Delay-slot flag of the last recorded entry |
| cause_code_o | output | 5 | Last recorded exception code |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch target, valid while redirect_o is high |

## Verification
The properties assume that requests last one cycle and that every input is stable around the rising edge. They also assume that the inputs stay low while reset is held, because the timing checks look one cycle back. The bench changes its inputs only on falling edges and holds every request and write low through reset. Its stimulus includes simultaneous exception, return and write requests, so the priority rules are checked against the reference model rather than avoided.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int unsigned CODE_W = 5;

   localparam logic [CODE_W-1:0] CODE_INTR   = 5'd0;
   localparam logic [CODE_W-1:0] CODE_TLB_LD = 5'd2;
   localparam logic [CODE_W-1:0] CODE_TLB_ST = 5'd3;

   typedef enum logic [1:0] {
      WSEL_EPC    = 2'd0,
      WSEL_STATUS = 2'd1,
      WSEL_CAUSE  = 2'd2,
      WSEL_NONE   = 2'd3
   } wsel_e;

   typedef enum logic [1:0] {
      CLS_TLB   = 2'd0,
      CLS_INTR  = 2'd1,
      CLS_OTHER = 2'd2
   } exc_class_e;

   function automatic exc_class_e classify(input logic [CODE_W-1:0] code);
      if (code == CODE_TLB_LD || code == CODE_TLB_ST) return CLS_TLB;
      if (code == CODE_INTR) return CLS_INTR;
      return CLS_OTHER;
   endfunction
endpackage

// File: rtl/trap_vec_sel.sv
module trap_vec_sel
   import trap_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] BASE_NORMAL = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] BASE_BOOT   = 32'hBFC0_0200,
   parameter logic [ADDR_W-1:0] OFF_REFILL  = 32'h0000_0000,
   parameter logic [ADDR_W-1:0] OFF_GENERAL = 32'h0000_0180,
   parameter logic [ADDR_W-1:0] OFF_INTVEC  = 32'h0000_0200,
   parameter bit                COMBINE_OR  = 1'b0
) (
   input  logic              exl,
   input  logic              bev,
   input  logic              iv,
   input  logic              tlb_nomatch,
   input  logic [CODE_W-1:0] code,
   output logic [ADDR_W-1:0] target
);
   localparam logic [ADDR_W-1:0] OFF_MASK = OFF_REFILL | OFF_GENERAL | OFF_INTVEC;

   exc_class_e        cls;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] base;

   always_comb begin
      cls = classify(code);
      if (exl) begin
         offset = OFF_GENERAL;
      end else begin
         unique case (cls)
            CLS_TLB:  offset = tlb_nomatch ? OFF_REFILL : OFF_GENERAL;
            CLS_INTR: offset = iv ? OFF_INTVEC : OFF_GENERAL;
            default:  offset = OFF_GENERAL;
         endcase
      end
      base = bev ? BASE_BOOT : BASE_NORMAL;
   end

   generate
      if (COMBINE_OR) begin : g_or_combine
         if (((BASE_NORMAL | BASE_BOOT) & OFF_MASK) != '0) begin : g_bad_align
            $error("trap_vec_sel: OR combine needs bases clear of offset bits");
         end
         assign target = base | offset;
      end else begin : g_add_combine
         assign target = base + offset;
      end
   endgenerate
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
   import trap_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INSN_BYTES = 4,
   parameter int unsigned EXL_BIT    = 1,
   parameter int unsigned BEV_BIT    = 22,
   parameter int unsigned IV_BIT     = 23,
   parameter bit          BEV_RESET  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_exc,
   input  logic              take_ret,
   input  logic              take_wr,
   input  wsel_e             wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [CODE_W-1:0] code,
   input  logic [ADDR_W-1:0] pc,
   input  logic              in_dslot,
   output logic [ADDR_W-1:0] epc,
   output logic              exl,
   output logic              bev,
   output logic              iv,
   output logic              bd,
   output logic [CODE_W-1:0] cause_code
);
   localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(INSN_BYTES);

   logic              save_ctx;
   logic [ADDR_W-1:0] save_pc;

   assign save_ctx = take_exc & ~exl;
   assign save_pc  = in_dslot ? (pc - SLOT_STEP) : pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc <= '0;
         bd  <= 1'b0;
      end else if (save_ctx) begin
         epc <= save_pc;
         bd  <= in_dslot;
      end else if (take_wr && wr_sel == WSEL_EPC) begin
         epc <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exl <= 1'b0;
         bev <= BEV_RESET;
      end else if (take_exc) begin
         exl <= 1'b1;
      end else if (take_ret) begin
         exl <= 1'b0;
      end else if (take_wr && wr_sel == WSEL_STATUS) begin
         exl <= wr_data[EXL_BIT];
         bev <= wr_data[BEV_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iv         <= 1'b0;
         cause_code <= '0;
      end else if (take_exc) begin
         cause_code <= code;
      end else if (take_wr && wr_sel == WSEL_CAUSE) begin
         iv <= wr_data[IV_BIT];
      end
   end
endmodule

// File: rtl/trap_redirect_reg.sv
module trap_redirect_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] next_pc,
   output logic              redirect,
   output logic [ADDR_W-1:0] redirect_pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect    <= 1'b0;
         redirect_pc <= '0;
      end else begin
         redirect <= fire;
         if (fire) redirect_pc <= next_pc;
      end
   end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       INSN_BYTES  = 4,
   parameter int unsigned       EXL_BIT     = 1,
   parameter int unsigned       BEV_BIT     = 22,
   parameter int unsigned       IV_BIT      = 23,
   parameter bit                BEV_RESET   = 1'b0,
   parameter bit                COMBINE_OR  = 1'b0,
   parameter logic [ADDR_W-1:0] BASE_NORMAL = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] BASE_BOOT   = 32'hBFC0_0200,
   parameter logic [ADDR_W-1:0] OFF_REFILL  = 32'h0000_0000,
   parameter logic [ADDR_W-1:0] OFF_GENERAL = 32'h0000_0180,
   parameter logic [ADDR_W-1:0] OFF_INTVEC  = 32'h0000_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [4:0]        exc_code,
   input  logic              exc_tlb_nomatch,
   input  logic [ADDR_W-1:0] exc_pc,
   input  logic              exc_in_dslot,
   input  logic              eret_req,
   input  logic              sw_wr_en,
   input  logic [1:0]        sw_wr_sel,
   input  logic [ADDR_W-1:0] sw_wr_data,
   output logic [ADDR_W-1:0] epc_o,
   output logic              exl_o,
   output logic              bev_o,
   output logic              iv_o,
   output logic              bd_o,
   output logic [4:0]        cause_code_o,
   output logic              redirect_o,
   output logic [ADDR_W-1:0] redirect_pc_o
);
   localparam int unsigned TOP_FIELD = (IV_BIT > BEV_BIT) ? IV_BIT : BEV_BIT;

   generate
      if (TOP_FIELD >= ADDR_W || EXL_BIT >= ADDR_W) begin : g_bad_field
         $error("trap_entry_unit: control field beyond data width");
      end
      if (CODE_W != 5) begin : g_bad_code
         $error("trap_entry_unit: exception code width must be 5");
      end
      if (INSN_BYTES == 0) begin : g_bad_step
         $error("trap_entry_unit: instruction size must be nonzero");
      end
   endgenerate

   logic              take_exc;
   logic              take_ret;
   logic              take_wr;
   logic [ADDR_W-1:0] vec_target;
   logic [ADDR_W-1:0] next_pc;

   assign take_exc = exc_req;
   assign take_ret = eret_req & ~exc_req;
   assign take_wr  = sw_wr_en & ~exc_req & ~eret_req;
   assign next_pc  = take_exc ? vec_target : epc_o;

   trap_vec_sel #(
      .ADDR_W      (ADDR_W),
      .BASE_NORMAL (BASE_NORMAL),
      .BASE_BOOT   (BASE_BOOT),
      .OFF_REFILL  (OFF_REFILL),
      .OFF_GENERAL (OFF_GENERAL),
      .OFF_INTVEC  (OFF_INTVEC),
      .COMBINE_OR  (COMBINE_OR)
   ) u_vec (
      .exl         (exl_o),
      .bev         (bev_o),
      .iv          (iv_o),
      .tlb_nomatch (exc_tlb_nomatch),
      .code        (exc_code),
      .target      (vec_target)
   );

   trap_state_regs #(
      .ADDR_W     (ADDR_W),
      .INSN_BYTES (INSN_BYTES),
      .EXL_BIT    (EXL_BIT),
      .BEV_BIT    (BEV_BIT),
      .IV_BIT     (IV_BIT),
      .BEV_RESET  (BEV_RESET)
   ) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_exc   (take_exc),
      .take_ret   (take_ret),
      .take_wr    (take_wr),
      .wr_sel     (wsel_e'(sw_wr_sel)),
      .wr_data    (sw_wr_data),
      .code       (exc_code),
      .pc         (exc_pc),
      .in_dslot   (exc_in_dslot),
      .epc        (epc_o),
      .exl        (exl_o),
      .bev        (bev_o),
      .iv         (iv_o),
      .bd         (bd_o),
      .cause_code (cause_code_o)
   );

   trap_redirect_reg #(
      .ADDR_W (ADDR_W)
   ) u_redir (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (take_exc | take_ret),
      .next_pc     (next_pc),
      .redirect    (redirect_o),
      .redirect_pc (redirect_pc_o)
   );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INSN_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [4:0]        exc_code,
   input logic [ADDR_W-1:0] exc_pc,
   input logic              exc_in_dslot,
   input logic              eret_req,
   input logic [ADDR_W-1:0] epc_o,
   input logic              exl_o,
   input logic              bd_o,
   input logic [4:0]        cause_code_o,
   input logic              redirect_o
);
   assert_ctx_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !exl_o && !exc_in_dslot) |=> (epc_o == $past(exc_pc) && !bd_o));

   assert_ctx_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !exl_o && exc_in_dslot) |=>
      (epc_o == $past(exc_pc) - ADDR_W'(INSN_BYTES) && bd_o));

   assert_nested_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && exl_o) |=> ($stable(epc_o) && $stable(bd_o)));

   assert_entry_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (exl_o && cause_code_o == $past(exc_code)));

   assert_strobe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req || eret_req) |=> redirect_o);

   assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !eret_req) |=> !redirect_o);

   assert_return_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && !exc_req) |=> !exl_o);

   assert_exc_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && exc_req) |=> exl_o);
endmodule

bind trap_entry_unit trap_entry_chk #(
   .ADDR_W     (ADDR_W),
   .INSN_BYTES (INSN_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exc_req      (exc_req),
   .exc_code     (exc_code),
   .exc_pc       (exc_pc),
   .exc_in_dslot (exc_in_dslot),
   .eret_req     (eret_req),
   .epc_o        (epc_o),
   .exl_o        (exl_o),
   .bd_o         (bd_o),
   .cause_code_o (cause_code_o),
   .redirect_o   (redirect_o)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_code = '0;
   logic        exc_tlb_nomatch = 1'b0;
   logic [31:0] exc_pc = '0;
   logic        exc_in_dslot = 1'b0;
   logic        eret_req = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [1:0]  sw_wr_sel = '0;
   logic [31:0] sw_wr_data = '0;
   logic [31:0] epc_o;
   logic        exl_o, bev_o, iv_o, bd_o;
   logic [4:0]  cause_code_o;
   logic        redirect_o;
   logic [31:0] redirect_pc_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   trap_entry_unit u_dut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
      .exc_tlb_nomatch(exc_tlb_nomatch), .exc_pc(exc_pc), .exc_in_dslot(exc_in_dslot),
      .eret_req(eret_req), .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel),
      .sw_wr_data(sw_wr_data), .epc_o(epc_o), .exl_o(exl_o), .bev_o(bev_o),
      .iv_o(iv_o), .bd_o(bd_o), .cause_code_o(cause_code_o),
      .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
   );

   // behavioural reference state
   logic [31:0] m_epc = '0, m_rpc = '0;
   logic        m_exl = 0, m_bev = 0, m_iv = 0, m_bd = 0, m_redir = 0;
   logic [4:0]  m_code = '0;

   function automatic logic [31:0] expect_vector(input logic exl, input logic bev,
         input logic iv, input logic [4:0] code, input logic nomatch);
      logic [31:0] off;
      if (exl) off = 32'h180;
      else if (code == 5'd2 || code == 5'd3) off = nomatch ? 32'h0 : 32'h180;
      else if (code == 5'd0) off = iv ? 32'h200 : 32'h180;
      else off = 32'h180;
      return (bev ? 32'hBFC0_0200 : 32'h8000_0000) + off;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_epc = '0; m_rpc = '0; m_exl = 0; m_bev = 0; m_iv = 0;
         m_bd = 0; m_redir = 0; m_code = '0;
      end else begin
         m_redir = 0;
         if (exc_req) begin
            m_rpc = expect_vector(m_exl, m_bev, m_iv, exc_code, exc_tlb_nomatch);
            if (!m_exl) begin
               m_epc = exc_in_dslot ? exc_pc - 32'd4 : exc_pc;
               m_bd  = exc_in_dslot;
            end
            m_exl = 1; m_code = exc_code; m_redir = 1;
         end else if (eret_req) begin
            m_rpc = m_epc; m_exl = 0; m_redir = 1;
         end else if (sw_wr_en) begin
            case (sw_wr_sel)
               2'd0: m_epc = sw_wr_data;
               2'd1: begin m_exl = sw_wr_data[1]; m_bev = sw_wr_data[22]; end
               2'd2: m_iv = sw_wr_data[23];
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 epc", epc_o, m_epc);
         check("R3 bd", {31'b0, bd_o}, {31'b0, m_bd});
         check("R8 exl", {31'b0, exl_o}, {31'b0, m_exl});
         check("R8 code", {27'b0, cause_code_o}, {27'b0, m_code});
         check("R13 bev", {31'b0, bev_o}, {31'b0, m_bev});
         check("R13 iv", {31'b0, iv_o}, {31'b0, m_iv});
         check("R10 strobe", {31'b0, redirect_o}, {31'b0, m_redir});
         if (m_redir) check("R9 target", redirect_pc_o, m_rpc);
      end
   end

   task automatic idle();
      exc_req = 0; eret_req = 0; sw_wr_en = 0;
      exc_in_dslot = 0; exc_tlb_nomatch = 0;
   endtask

   // drive one request cycle; returns at the falling edge where results are visible
   task automatic raise(input logic [4:0] code, input logic [31:0] pc,
         input logic slot, input logic nm);
      exc_req = 1; exc_code = code; exc_pc = pc; exc_in_dslot = slot; exc_tlb_nomatch = nm;
      @(negedge clk); idle();
   endtask

   task automatic ret();
      eret_req = 1; @(negedge clk); idle();
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      sw_wr_en = 1; sw_wr_sel = sel; sw_wr_data = d; @(negedge clk); idle();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      logic [31:0] lfsr = 32'h1ACE_B00C;
      idle();
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 exl", {31'b0, exl_o}, 32'd0);
      check("R1 epc", epc_o, 32'd0);
      check("R1 strobe", {31'b0, redirect_o}, 32'd0);
      check("R1 code", {27'b0, cause_code_o}, 32'd0);

      // R7 general code, plain entry (R2)
      raise(5'd8, 32'h0040_0100, 0, 0);
      check("R7 target", redirect_pc_o, 32'h8000_0180);
      check("R2 epc", epc_o, 32'h0040_0100);
      @(negedge clk);
      check("R10 single cycle", {31'b0, redirect_o}, 32'd0);

      // R4 nested entry keeps context, forced general offset
      raise(5'd2, 32'h0040_0900, 1, 1);
      check("R4 target", redirect_pc_o, 32'h8000_0180);
      check("R4 epc", epc_o, 32'h0040_0100);
      check("R4 bd", {31'b0, bd_o}, 32'd0);
      check("R8 code nested", {27'b0, cause_code_o}, 32'd2);

      // R11 return
      ret();
      check("R11 target", redirect_pc_o, 32'h0040_0100);
      check("R11 exl", {31'b0, exl_o}, 32'd0);

      // R5 no-match refill in delay slot (R3)
      raise(5'd2, 32'h0040_0200, 1, 1);
      check("R5 refill target", redirect_pc_o, 32'h8000_0000);
      check("R3 epc", epc_o, 32'h0040_01FC);
      check("R3 bd", {31'b0, bd_o}, 32'd1);
      ret();
      raise(5'd3, 32'h0040_0300, 0, 0);
      check("R5 matched target", redirect_pc_o, 32'h8000_0180);
      ret();

      // R6 interrupt with and without vector bit
      wr(2'd2, 32'h0080_0000);
      raise(5'd0, 32'h0040_0400, 0, 0);
      check("R6 iv=1 target", redirect_pc_o, 32'h8000_0200);
      ret();
      wr(2'd2, 32'h0);
      raise(5'd0, 32'h0040_0404, 0, 0);
      check("R6 iv=0 target", redirect_pc_o, 32'h8000_0180);
      ret();

      // R9 boot base
      wr(2'd2, 32'h0080_0000);
      wr(2'd1, 32'h0040_0000);
      check("R13 bev", {31'b0, bev_o}, 32'd1);
      raise(5'd0, 32'h0040_0500, 0, 0);
      check("R9 boot target", redirect_pc_o, 32'hBFC0_0400);
      ret();
      wr(2'd1, 32'h0);

      // R12 exception with return together
      eret_req = 1;
      raise(5'd10, 32'h0040_0600, 0, 0);
      check("R12 exl", {31'b0, exl_o}, 32'd1);
      check("R12 target", redirect_pc_o, 32'h8000_0180);
      ret();

      // R13 write dropped under an exception; then sel 3 writes nothing
      sw_wr_en = 1; sw_wr_sel = 2'd0; sw_wr_data = 32'hDEAD_0000;
      raise(5'd9, 32'h0040_0700, 0, 0);
      check("R13 dropped write", epc_o, 32'h0040_0700);
      ret();
      wr(2'd3, 32'hFFFF_FFFF);
      check("R13 sel3 epc", epc_o, 32'h0040_0700);
      check("R13 sel3 bev", {31'b0, bev_o}, 32'd0);
      wr(2'd0, 32'h0000_1234);
      check("R13 epc write", epc_o, 32'h0000_1234);

      // mixed traffic against the model
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         exc_req = (lfsr[3:1] == 3'd0);
         eret_req = (lfsr[6:4] == 3'd1);
         sw_wr_en = lfsr[7] & lfsr[8];
         sw_wr_sel = lfsr[10:9];
         sw_wr_data = {lfsr[31:2], 2'b00} ^ {8'h0, lfsr[18], 22'h0, lfsr[19]};
         exc_code = lfsr[15:11] & (lfsr[16] ? 5'h03 : 5'h1F);
         exc_tlb_nomatch = lfsr[17];
         exc_in_dslot = lfsr[20];
         exc_pc = {8'h00, lfsr[27:6], 2'b00};
         @(negedge clk);
      end
      idle();
      @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end
endmodule